// File: doc/BRIEF.md
# Serial EEPROM Write Sequencer

This block sits behind a two-wire serial slave engine inside a 256-byte non-volatile memory model. The slave engine decodes the bus and hands it single-cycle events: a bus START, a write command that has been addressed to this device, the byte address, each data byte and the bus STOP. The sequencer holds the incoming data bytes in a one-row latch of eight slots. When STOP arrives after at least one data byte, it runs a programming cycle timed in clock cycles. The latch is copied into the storage array on the last clock of that cycle. The array comes out of reset holding FFh in every byte. A combinational read port lets the slave engine fetch bytes for its read commands.

Two write modes are supported, chosen by `mode_multi` when the byte address arrives. In page mode (`mode_multi` low) only the three low address bits advance, so the bytes wrap inside one eight-byte row. In multibyte mode (`mode_multi` high) up to four bytes are taken from any start address, and the full address advances across row boundaries. If those bytes land in two rows, the programming time is doubled. The `MULTI_EN` parameter builds the variant with the write-control pin, which has no multibyte mode. If `wr_protect` is high at STOP, the write is accepted on the bus but the array is left untouched. While `busy` is high, the slave engine withholds acknowledges, and the sequencer ignores every command input.

The controller has four states. IDLE moves to HDR on a write command. HDR moves to DATA on the byte address, and falls back to IDLE on START or STOP. DATA goes to PROG on a STOP that follows at least one data byte with protection low. It goes back to IDLE on START, or on a STOP with nothing latched or with protection high. It returns to HDR on a new write command. PROG goes to IDLE when the timer expires, and the latch is committed on that transition.

Top module: `eeprom_write_seq`

## Requirements
- R1: After reset every array byte reads FFh and `busy` is low.
- R2: In page mode, data byte k (from 0) is stored at address {A[7:3], (A[2:0]+k) mod 8}, where A is the byte address; the row bits A[7:3] never change.
- R3: In page mode, a ninth or later data byte overwrites the slot it wraps onto, and the value received last is the one stored.
- R4: In multibyte mode, data byte k (k < 4) is stored at (A+k) mod 256; a fifth or later data byte is discarded.
- R5: A STOP that follows at least one data byte raises `busy` on the next clock for exactly PROG_CYCLES clocks. The array does not change before that STOP. Its new contents become readable on the clock where `busy` falls.
- R6: In multibyte mode, when the stored bytes fall in two different rows (A[7:3] differs), `busy` lasts 2*PROG_CYCLES clocks.
- R7: A single data byte is written to its address the same way whatever the level of `mode_multi`.
- R8: With `wr_protect` high at STOP, the array is unchanged and `busy` stays low.
- R9: A write command that ends (START or STOP) before any data byte, such as a dummy write ahead of a random read, starts no cycle and changes nothing.
- R10: While `busy` is high, START, write command, address, data and STOP inputs have no effect: the cycle length stays the same and no extra data is stored.
- R11: With MULTI_EN = 0, `mode_multi` is ignored and every write follows the page-mode rules with a single-length cycle.
- R12: In multibyte mode, the address advances from FFh to 00h, and such a write counts as spanning two rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Pulse: START or repeated START seen on the bus |
| wr_begin | input | 1 | Pulse: write command addressed to this device |
| addr_valid | input | 1 | Pulse: byte address received |
| addr_byte | input | ADDR_W | Byte address |
| data_valid | input | 1 | Pulse: data byte received |
| data_byte | input | DATA_W | Data byte |
| bus_stop | input | 1 | Pulse: STOP seen on the bus |
| mode_multi | input | 1 | 1 selects multibyte mode, 0 selects page mode; sampled with the address |
| wr_protect | input | 1 | 1 blocks the array update; sampled at STOP |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | DATA_W | Array byte at `rd_addr` (combinational) |
| busy | output | 1 | Programming cycle in progress |

## Verification
A behavioural model built from associative arrays is stepped on every clock. The bench compares `busy` and a read of the array against it, using single bytes in both modes and a page write that wraps inside its row. It also uses a page write longer than a row, so the last value written must win. Multibyte writes are run inside one row, across a row boundary and across FFh to 00h. Together they separate the page wrap from the full-address increment, the four-byte cap, and the single cycle length from the doubled one. Protected writes, bare headers and commands issued while busy check that no cycle starts and no byte moves. A second instance built without multibyte mode receives the same stimulus, to show that the mode pin cannot reach it.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_PROG = 2'd3
    } wseq_state_t;

endpackage

// File: rtl/wseq_row_latch.sv
// Eight-slot row latch. Each slot holds a data byte, a valid flag and a
// flag telling whether the byte belongs to the row after the base row.
module wseq_row_latch #(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear,
    input  logic                                 load,
    input  logic [SLOT_W-1:0]                    idx,
    input  logic                                 hi_in,
    input  logic [DATA_W-1:0]                    din,
    output logic [(1<<SLOT_W)-1:0]               valid,
    output logic [(1<<SLOT_W)-1:0][DATA_W-1:0]   data,
    output logic [(1<<SLOT_W)-1:0]               hi,
    output logic                                 any_valid
);
    localparam int SLOTS = 1 << SLOT_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
            hi    <= '0;
            data  <= '0;
        end else if (clear) begin
            valid <= '0;
            hi    <= '0;
        end else if (load) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (idx == SLOT_W'(s)) begin
                    valid[s] <= 1'b1;
                    hi[s]    <= hi_in;
                    data[s]  <= din;
                end
            end
        end
    end

    assign any_valid = |valid;

endmodule

// File: rtl/wseq_prog_timer.sv
// Programming-cycle down counter: single or doubled length.
module wseq_prog_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dbl,
    output logic done
);
    localparam int CW = $clog2(2 * CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= dbl ? CW'(2 * CYCLES) : CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/wseq_cell_array.sv
// Storage array with all-ones reset and a one-clock commit of a row latch.
module wseq_cell_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SLOT_W = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 commit,
    input  logic [ADDR_W-SLOT_W-1:0]             base_row,
    input  logic [(1<<SLOT_W)-1:0]               slot_valid,
    input  logic [(1<<SLOT_W)-1:0][DATA_W-1:0]   slot_data,
    input  logic [(1<<SLOT_W)-1:0]               slot_hi,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [DATA_W-1:0]                    rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << SLOT_W;
    localparam int ROW_W = ADDR_W - SLOT_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] slot_addr [SLOTS];

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot_addr
            assign slot_addr[s] = {base_row + ROW_W'(slot_hi[s]), SLOT_W'(s)};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] <= '1;
            end
        end else if (commit) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (slot_valid[s]) begin
                    mem[slot_addr[s]] <= slot_data[s];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eeprom_write_seq.sv
module eeprom_write_seq
    import wseq_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SLOT_W      = 3,
    parameter int MULTI_MAX   = 4,
    parameter int PROG_CYCLES = 40,
    parameter bit MULTI_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              wr_begin,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_byte,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              bus_stop,
    input  logic              mode_multi,
    input  logic              wr_protect,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int ROW_W = ADDR_W - SLOT_W;
    localparam int SLOTS = 1 << SLOT_W;
    localparam int CNT_W = $clog2(MULTI_MAX + 1);

    wseq_state_t state_q, state_nxt;

    // Prioritised bus events: STOP > START > write command > address > data
    logic ev_stop, ev_start, ev_begin, ev_addr, ev_data;
    assign ev_stop  = bus_stop;
    assign ev_start = bus_start & ~bus_stop;
    assign ev_begin = wr_begin & ~bus_start & ~bus_stop;
    assign ev_addr  = addr_valid & ~wr_begin & ~bus_start & ~bus_stop;
    assign ev_data  = data_valid & ~addr_valid & ~wr_begin & ~bus_start & ~bus_stop;

    // Mode variant chosen at build time
    logic mode_eff;
    generate
        if (MULTI_EN) begin : g_multi
            assign mode_eff = mode_multi;
        end else begin : g_page_only
            assign mode_eff = 1'b0;
        end
    endgenerate

    // Command context
    logic [ADDR_W-1:0] ptr_q;
    logic [ROW_W-1:0]  base_row_q;
    logic              multi_q;
    logic              wrapped_q;
    logic              span_q;
    logic [CNT_W-1:0]  taken_q;

    // Control strobes
    logic latch_clear, addr_load, data_take, tmr_start, commit;
    logic tmr_done;

    logic [SLOTS-1:0]             slot_valid;
    logic [SLOTS-1:0][DATA_W-1:0] slot_data;
    logic [SLOTS-1:0]             slot_hi;
    logic                         any_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_begin) state_nxt = ST_HDR;
            end
            ST_HDR: begin
                if (ev_stop || ev_start) state_nxt = ST_IDLE;
                else if (ev_begin)       state_nxt = ST_HDR;
                else if (ev_addr)        state_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (ev_stop)       state_nxt = (any_valid && !wr_protect) ? ST_PROG : ST_IDLE;
                else if (ev_start) state_nxt = ST_IDLE;
                else if (ev_begin) state_nxt = ST_HDR;
            end
            ST_PROG: begin
                if (tmr_done) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Output and strobe logic
    always_comb begin
        latch_clear = 1'b0;
        addr_load   = 1'b0;
        data_take   = 1'b0;
        tmr_start   = 1'b0;
        commit      = 1'b0;
        busy        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                latch_clear = ev_begin;
            end
            ST_HDR: begin
                latch_clear = ev_begin;
                addr_load   = ev_addr;
            end
            ST_DATA: begin
                latch_clear = ev_begin;
                data_take   = ev_data && (!multi_q || taken_q < CNT_W'(MULTI_MAX));
                tmr_start   = ev_stop && any_valid && !wr_protect;
            end
            ST_PROG: begin
                busy   = 1'b1;
                commit = tmr_done;
            end
            default: ;
        endcase
    end

    // Address pointer and command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            base_row_q <= '0;
            multi_q    <= 1'b0;
            wrapped_q  <= 1'b0;
            span_q     <= 1'b0;
            taken_q    <= '0;
        end else if (addr_load) begin
            ptr_q      <= addr_byte;
            base_row_q <= addr_byte[ADDR_W-1:SLOT_W];
            multi_q    <= mode_eff;
            wrapped_q  <= 1'b0;
            span_q     <= 1'b0;
            taken_q    <= '0;
        end else if (data_take) begin
            if (multi_q) begin
                ptr_q   <= ptr_q + 1'b1;
                taken_q <= taken_q + 1'b1;
                if (&ptr_q[SLOT_W-1:0]) wrapped_q <= 1'b1;
            end else begin
                ptr_q[SLOT_W-1:0] <= ptr_q[SLOT_W-1:0] + 1'b1;
            end
            if (wrapped_q) span_q <= 1'b1;
        end
    end

    wseq_row_latch #(
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (latch_clear),
        .load      (data_take),
        .idx       (ptr_q[SLOT_W-1:0]),
        .hi_in     (wrapped_q),
        .din       (data_byte),
        .valid     (slot_valid),
        .data      (slot_data),
        .hi        (slot_hi),
        .any_valid (any_valid)
    );

    wseq_prog_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .dbl   (span_q),
        .done  (tmr_done)
    );

    wseq_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .base_row   (base_row_q),
        .slot_valid (slot_valid),
        .slot_data  (slot_data),
        .slot_hi    (slot_hi),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/wseq_checker.sv
module wseq_checker #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_stop,
    input logic              wr_protect,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    logic busy_d;
    int   run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_d <= 1'b0;
            run_q  <= 0;
        end else begin
            busy_d <= busy;
            if (busy && !busy_d) run_q <= 1;
            else if (busy)       run_q <= run_q + 1;
        end
    end

    // R5 / R6: a finished cycle lasted one or two programming periods
    p_cycle_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_d && !busy) |-> (run_q == PROG_CYCLES || run_q == 2 * PROG_CYCLES));

    // R6: a cycle never runs past the doubled length
    p_cycle_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q <= 2 * PROG_CYCLES));

    // R5: busy only rises on the clock after a STOP
    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop));

    // R8: a protected STOP outside a cycle never starts one
    p_protect_no_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && wr_protect && !busy) |=> !busy);

    // R10: array contents frozen while the cycle runs
    p_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(rd_addr)) |-> $stable(rd_data));

    // R9: outside the commit clock the array never changes
    p_no_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

bind eeprom_write_seq wseq_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_wseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_stop   (bus_stop),
    .wr_protect (wr_protect),
    .busy       (busy),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
);

// File: tb/eeprom_write_seq_bench.sv
`timescale 1ns/1ps
module eeprom_write_seq_bench;
    localparam int N = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 0, wr_begin = 0, addr_valid = 0, data_valid = 0, bus_stop = 0;
    logic [7:0] addr_byte = 0, data_byte = 0;
    logic       mode_multi = 0, wr_protect = 0;
    logic [7:0] rd_addr = 0;
    logic [7:0] rd_data, rd_data_pg;
    logic       busy, busy_pg;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    finished = 0;

    always #2.5 clk = ~clk;

    eeprom_write_seq #(.PROG_CYCLES(N)) u_eeprom_write_seq (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .wr_begin(wr_begin),
        .addr_valid(addr_valid), .addr_byte(addr_byte), .data_valid(data_valid),
        .data_byte(data_byte), .bus_stop(bus_stop), .mode_multi(mode_multi),
        .wr_protect(wr_protect), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

    eeprom_write_seq #(.PROG_CYCLES(N), .MULTI_EN(1'b0)) u_eeprom_write_seq_pg (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .wr_begin(wr_begin),
        .addr_valid(addr_valid), .addr_byte(addr_byte), .data_valid(data_valid),
        .data_byte(data_byte), .bus_stop(bus_stop), .mode_multi(mode_multi),
        .wr_protect(wr_protect), .rd_addr(rd_addr), .rd_data(rd_data_pg), .busy(busy_pg));

    // ---------------- behavioural reference model (main instance) ----------
    logic [7:0] m_mem [256];
    logic [7:0] m_pend [int];
    int m_phase, m_ptr, m_cnt, m_first_row, m_busy_left;
    bit m_multi, m_span;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) m_mem[a] = 8'hFF;
            m_pend.delete();
            m_phase = 0; m_busy_left = 0; m_ptr = 0; m_cnt = 0; m_span = 0; m_multi = 0; m_first_row = 0;
        end else if (m_busy_left > 0) begin
            m_busy_left--;
            if (m_busy_left == 0) foreach (m_pend[a]) m_mem[a] = m_pend[a];
        end else if (bus_stop) begin
            if (m_phase == 2 && m_pend.num() > 0 && !wr_protect) m_busy_left = m_span ? 2 * N : N;
            m_phase = 0;
        end else if (bus_start) begin
            m_phase = 0;
        end else if (wr_begin) begin
            m_phase = 1; m_pend.delete();
        end else if (addr_valid) begin
            if (m_phase == 1) begin
                m_phase = 2; m_ptr = addr_byte; m_cnt = 0; m_multi = mode_multi;
                m_span = 0; m_first_row = addr_byte / 8;
            end
        end else if (data_valid && m_phase == 2) begin
            if (!m_multi) begin
                m_pend[m_ptr] = data_byte;
                m_ptr = (m_ptr / 8) * 8 + ((m_ptr + 1) % 8);
            end else if (m_cnt < 4) begin
                m_pend[m_ptr] = data_byte;
                if (m_ptr / 8 != m_first_row) m_span = 1;
                m_ptr = (m_ptr + 1) % 256;
                m_cnt++;
            end
        end
    end

    // ---------------- busy run-length tracking ------------------------------
    int run_m = 0, last_m = 0, run_p = 0, last_p = 0;
    always @(posedge clk) begin
        if (busy) run_m <= run_m + 1; else if (run_m != 0) begin last_m <= run_m; run_m <= 0; end
        if (busy_pg) run_p <= run_p + 1; else if (run_p != 0) begin last_p <= run_p; run_p <= 0; end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !finished) begin
            chk({cur_req, " busy"}, busy, (m_busy_left > 0));
            chk({cur_req, " rd_data"}, rd_data, m_mem[rd_addr]);
        end
    end

    // ---------------- stimulus helpers ---------------------------------------
    task automatic clear_all();
        bus_start = 0; wr_begin = 0; addr_valid = 0; data_valid = 0; bus_stop = 0;
    endtask

    task automatic ev(input int kind, input logic [7:0] v);
        @(negedge clk);
        case (kind)
            0: bus_start = 1;
            1: wr_begin = 1;
            2: begin addr_valid = 1; addr_byte = v; end
            3: begin data_valid = 1; data_byte = v; end
            default: bus_stop = 1;
        endcase
        @(negedge clk);
        clear_all();
    endtask

    task automatic header(input logic [7:0] a);
        ev(0, 0); ev(1, 0); ev(2, a);
    endtask

    task automatic settle();
        repeat (2 * N + 6) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic [7:0] dp);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data; dp = rd_data_pg;
    endtask

    task automatic expect_byte(input string req, input logic [7:0] a, input logic [7:0] e);
        logic [7:0] d, dp;
        rd(a, d, dp);
        chk(req, d, e);
    endtask

    task automatic expect_pg(input string req, input logic [7:0] a, input logic [7:0] e);
        logic [7:0] d, dp;
        rd(a, d, dp);
        chk(req, dp, e);
    endtask

    // ---------------- watchdog ----------------------------------------------
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- test sequence -----------------------------------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state, scan whole array
        cur_req = "R1";
        chk("R1 busy", busy, 0);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] d, dp;
            rd(a[7:0], d, dp);
            if (a % 64 == 0) chk("R1 byte", d, 8'hFF);
        end

        // R7 + R5: single byte in each mode; no change before STOP
        cur_req = "R7";
        mode_multi = 0;
        header(8'h10); ev(3, 8'hA5);
        expect_byte("R5 before stop", 8'h10, 8'hFF);
        ev(4, 0);
        settle();
        chk("R5 busy length", last_m, N);
        expect_byte("R7 page-level byte", 8'h10, 8'hA5);
        mode_multi = 1;
        header(8'h21); ev(3, 8'h5A); ev(4, 0);
        settle();
        expect_byte("R7 multi-level byte", 8'h21, 8'h5A);
        chk("R7 busy length", last_m, N);

        // R2: page write wrapping inside its row
        cur_req = "R2";
        mode_multi = 0;
        header(8'h35);
        for (int i = 0; i < 5; i++) ev(3, 8'hC0 + 8'(i));
        ev(4, 0);
        settle();
        expect_byte("R2 0x35", 8'h35, 8'hC0);
        expect_byte("R2 0x37", 8'h37, 8'hC2);
        expect_byte("R2 0x30 wrap", 8'h30, 8'hC3);
        expect_byte("R2 0x31 wrap", 8'h31, 8'hC4);
        expect_byte("R2 next row untouched", 8'h38, 8'hFF);

        // R3: ten bytes into one row, last value wins
        cur_req = "R3";
        header(8'h40);
        for (int i = 0; i < 10; i++) ev(3, 8'hD0 + 8'(i));
        ev(4, 0);
        settle();
        expect_byte("R3 0x40 overwritten", 8'h40, 8'hD8);
        expect_byte("R3 0x41 overwritten", 8'h41, 8'hD9);
        expect_byte("R3 0x47", 8'h47, 8'hD7);
        expect_byte("R3 0x48 untouched", 8'h48, 8'hFF);
        chk("R3 busy length", last_m, N);

        // R4: multibyte, six bytes sent, four kept, one row
        cur_req = "R4";
        mode_multi = 1;
        header(8'h52);
        for (int i = 0; i < 6; i++) ev(3, 8'hE0 + 8'(i));
        ev(4, 0);
        settle();
        expect_byte("R4 0x55", 8'h55, 8'hE3);
        expect_byte("R4 fifth discarded", 8'h56, 8'hFF);
        chk("R4 busy length", last_m, N);

        // R6: multibyte across a row boundary doubles the cycle
        cur_req = "R6";
        header(8'h6E);
        for (int i = 0; i < 4; i++) ev(3, 8'h10 + 8'(i));
        ev(4, 0);
        settle();
        chk("R6 busy length", last_m, 2 * N);
        expect_byte("R6 0x6F", 8'h6F, 8'h11);
        expect_byte("R6 0x70", 8'h70, 8'h12);
        expect_byte("R6 0x71", 8'h71, 8'h13);

        // R12: multibyte from 0xFE advancing past 0xFF to 0x00
        cur_req = "R12";
        header(8'hFE);
        for (int i = 0; i < 3; i++) ev(3, 8'h20 + 8'(i));
        ev(4, 0);
        settle();
        chk("R12 busy length", last_m, 2 * N);
        expect_byte("R12 0xFF", 8'hFF, 8'h21);
        expect_byte("R12 0x00", 8'h00, 8'h22);

        // R8: protected write changes nothing and starts no cycle
        cur_req = "R8";
        mode_multi = 0; wr_protect = 1;
        last_m = 0;
        header(8'h80); ev(3, 8'h99); ev(3, 8'h98); ev(4, 0);
        settle();
        wr_protect = 0;
        chk("R8 no cycle", last_m, 0);
        expect_byte("R8 0x80 untouched", 8'h80, 8'hFF);

        // R9: dummy write then repeated START, and a header ended by STOP
        cur_req = "R9";
        header(8'h90); ev(0, 0); ev(4, 0);
        header(8'h91); ev(4, 0);
        settle();
        chk("R9 no cycle", last_m, 0);
        expect_byte("R9 0x90 untouched", 8'h90, 8'hFF);

        // R10: full command while busy is ignored
        cur_req = "R10";
        header(8'h12); ev(3, 8'h44); ev(4, 0);
        header(8'hA0); ev(3, 8'h77); ev(4, 0);
        settle();
        chk("R10 busy length", last_m, N);
        expect_byte("R10 0x12 written", 8'h12, 8'h44);
        expect_byte("R10 0xA0 untouched", 8'hA0, 8'hFF);

        // R11: build without multibyte ignores mode_multi
        cur_req = "R11";
        mode_multi = 1;
        header(8'h06);
        for (int i = 0; i < 4; i++) ev(3, 8'h30 + 8'(i));
        ev(4, 0);
        settle();
        chk("R11 page-only busy length", last_p, N);
        chk("R11 main busy length", last_m, 2 * N);
        expect_pg("R11 page-only 0x00", 8'h00, 8'h32);
        expect_pg("R11 page-only 0x01", 8'h01, 8'h33);
        expect_pg("R11 page-only 0x08", 8'h08, 8'hFF);
        expect_byte("R11 main 0x08", 8'h08, 8'h32);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule